// File: doc/BRIEF.md
# Serial Port FIFO Status Tracker

This block builds the 32-bit read-only status word of a synchronous serial controller that has a transmit FIFO, a receive FIFO and a shift register on each side. It does not move any data. It watches single-cycle event strobes from the rest of the controller and keeps the state the status word shows:

- two occupancy counters;
- the ready, empty and overrun flags;
- a bank of sticky event flags that software clears by reading the status word.

The transmit counter counts free FIFO entries. The receive counter counts words not yet read. Transmit-empty is raised only once the FIFO is drained and the transmit shifter has also gone idle.

Every field of the status word comes from a register inside the block, or from a gate on those registers. An event seen on a rising clock edge therefore appears in the word one cycle later. A status-read strobe clears the sticky flags on the edge that ends the read cycle. An event that lands in that same cycle is kept. The FIFO depth is a parameter, `DEPTH`, and must not exceed 15 so that it fits a 4-bit field.

Top module: `serport_status`

## Requirements
- R1: Bits 31:28 hold the unread receive word count. It rises by one on `rx_load`, falls by one on `rx_rd`, stays unchanged when both are present, and saturates at 0 and at `DEPTH`.
- R2: Bits 27:24 hold the transmit free-entry count. It reads 0 while `tx_en` is low and is loaded with `DEPTH` in the first cycle `tx_en` is high. After that it falls by one on `tx_wr`, rises by one on `tx_xfer`, stays unchanged when both are present, and saturates at 0 and at `DEPTH`.
- R3: Bit 17 shows `rx_en` and bit 16 shows `tx_en`, each as sampled on the previous clock edge.
- R4: Bits 11, 10, 9 and 8 are sticky flags for `rx_sync_evt`, `tx_sync_evt`, `cmp1_evt` and `cmp0_evt` respectively. Each flag is set the cycle after its event, stays set through idle cycles, and is cleared the cycle after a `stat_rd`.
- R5: If an event arrives in the same cycle as `stat_rd`, its sticky flag (bits 11:8 or 5) is still set after the read.
- R6: Bit 5 (overrun) is sticky. It sets when `rx_load` occurs while a received word is still unread and is not being read in that same cycle. It clears on `stat_rd`.
- R7: Bit 4 is 1 whenever the unread receive count is non-zero, and 0 otherwise.
- R8: Bit 0 is 1 exactly when the transmit free count equals `DEPTH`, which means the transmit FIFO is empty.
- R9: Bit 1 is 1 exactly when bit 0 is 1 and `tx_shift_idle` was high on the previous clock edge.
- R10: After reset the whole word is 0. Bits 23:18, 15:12, 7:6 and 3:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable level |
| tx_en | input | 1 | Transmitter enable level |
| tx_wr | input | 1 | Word written into the transmit FIFO |
| tx_xfer | input | 1 | Word moved from the transmit FIFO into the shifter |
| tx_shift_idle | input | 1 | Transmit shifter has no word in flight |
| rx_load | input | 1 | Receive shifter loaded a word into the receive FIFO |
| rx_rd | input | 1 | Word read from the receive FIFO |
| rx_sync_evt | input | 1 | Receive frame-sync event |
| tx_sync_evt | input | 1 | Transmit frame-sync event |
| cmp1_evt | input | 1 | Compare-1 match event |
| cmp0_evt | input | 1 | Compare-0 match event |
| stat_rd | input | 1 | Status word is being read this cycle |
| status_word | output | 32 | Status word |

## Verification
The counters are driven in several ways:

- single increments and single decrements;
- increment and decrement in the same cycle, which must leave the count unchanged and so shows that the simultaneous case is handled;
- runs past both ends, which show that the count saturates rather than wraps.

The transmit counter is also disabled and then re-enabled, to expose the forced-zero and reload behaviour.

The sticky flags are tried in three patterns: an event alone, an event followed by idle cycles, and an event that coincides with a read. Together these separate a flag that latches correctly from one that is only a pulse, and from one that loses its event during the read.

Overrun is tried in two cases. A load into a non-empty FIFO must set it. A load while the only unread word is being read in the same cycle must not.

// File: rtl/serport_status_pkg.sv
package serport_status_pkg;

    localparam int FIELD_W    = 4;
    localparam int NUM_STICKY = 5;

    // sticky flag slots
    localparam int STK_RXSYNC = 0;
    localparam int STK_TXSYNC = 1;
    localparam int STK_CMP1   = 2;
    localparam int STK_CMP0   = 3;
    localparam int STK_OVR    = 4;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
        logic tx_idle;
    } ctl_t;

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W    = 4,
    parameter int MAXV = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_zero,
    input  logic         load_full,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX_C = W'(MAXV);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hold_zero) begin
            cnt_d = '0;
        end else if (load_full) begin
            cnt_d = MAX_C;
        end else if (inc && !dec && cnt_q != MAX_C) begin
            cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flg_d, flg_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            // a set in the clearing cycle wins so no event is lost
            always_comb flg_d[i] = set[i] | (flg_q[i] & ~clr);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;
endmodule

// File: rtl/serport_status.sv
module serport_status
    import serport_status_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic        tx_en,
    input  logic        tx_wr,
    input  logic        tx_xfer,
    input  logic        tx_shift_idle,
    input  logic        rx_load,
    input  logic        rx_rd,
    input  logic        rx_sync_evt,
    input  logic        tx_sync_evt,
    input  logic        cmp1_evt,
    input  logic        cmp0_evt,
    input  logic        stat_rd,
    output logic [31:0] status_word
);
    localparam logic [FIELD_W-1:0] FULL_C = FIELD_W'(DEPTH);
    localparam logic [FIELD_W-1:0] ONE_C  = FIELD_W'(1);

    ctl_t ctl_d, ctl_q;

    logic [FIELD_W-1:0]    rx_cnt, tx_free;
    logic [NUM_STICKY-1:0] stk_set, stk;
    logic                  ovr_evt, tx_rdy, tx_empty, rx_rdy;

    always_comb begin
        ctl_d.rx_en   = rx_en;
        ctl_d.tx_en   = tx_en;
        ctl_d.tx_idle = tx_shift_idle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    sat_counter #(.W(FIELD_W), .MAXV(DEPTH)) u_rx_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (1'b0),
        .load_full (1'b0),
        .inc       (rx_load),
        .dec       (rx_rd),
        .count     (rx_cnt)
    );

    sat_counter #(.W(FIELD_W), .MAXV(DEPTH)) u_tx_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (!tx_en),
        .load_full (tx_en && !ctl_q.tx_en),
        .inc       (tx_xfer),
        .dec       (tx_wr),
        .count     (tx_free)
    );

    // overrun: a load while an older word remains unread after this cycle
    always_comb begin
        ovr_evt = rx_load && (rx_cnt != '0) && !(rx_rd && rx_cnt == ONE_C);
        stk_set             = '0;
        stk_set[STK_RXSYNC] = rx_sync_evt;
        stk_set[STK_TXSYNC] = tx_sync_evt;
        stk_set[STK_CMP1]   = cmp1_evt;
        stk_set[STK_CMP0]   = cmp0_evt;
        stk_set[STK_OVR]    = ovr_evt;
    end

    sticky_bank #(.N(NUM_STICKY)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stk_set),
        .clr   (stat_rd),
        .flags (stk)
    );

    always_comb begin
        rx_rdy   = (rx_cnt != '0);
        tx_rdy   = (tx_free == FULL_C);
        tx_empty = tx_rdy && ctl_q.tx_idle;
        status_word = {rx_cnt, tx_free, 6'b0,
                       ctl_q.rx_en, ctl_q.tx_en, 4'b0,
                       stk[STK_RXSYNC], stk[STK_TXSYNC],
                       stk[STK_CMP1], stk[STK_CMP0], 2'b0,
                       stk[STK_OVR], rx_rdy, 2'b0, tx_empty, tx_rdy};
    end
endmodule

// File: rtl/serport_status_chk.sv
module serport_status_chk #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_en,
    input logic        tx_en,
    input logic        tx_wr,
    input logic        tx_xfer,
    input logic        rx_load,
    input logic        rx_rd,
    input logic        rx_sync_evt,
    input logic        stat_rd,
    input logic [31:0] status_word
);
    localparam logic [3:0] FULL_C = 4'(DEPTH);

    // R1: a lone load below the limit adds exactly one
    a_r1_rx_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && !rx_rd && status_word[31:28] != FULL_C)
        |=> status_word[31:28] == $past(status_word[31:28]) + 4'd1);

    // R1: never above the depth
    a_r1_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[31:28] <= FULL_C);

    // R2: disabled transmitter shows no free entries
    a_r2_tx_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> status_word[27:24] == 4'd0);

    // R2: a lone write on an enabled, non-empty count removes one
    a_r2_tx_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && status_word[16] && tx_wr && !tx_xfer && status_word[27:24] != 4'd0)
        |=> status_word[27:24] == $past(status_word[27:24]) - 4'd1);

    // R3: enables appear one cycle later
    a_r3_en_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status_word[17] == $past(rx_en) && status_word[16] == $past(tx_en)));

    // R4 / R5: an event always leaves its flag set, read or not
    a_r5_sync_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sync_evt |=> status_word[11]);

    // R4: a read with no event clears the flag
    a_r4_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !rx_sync_evt) |=> !status_word[11]);

    // R6: a load on a word that stays unread marks overrun
    a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && !rx_rd && status_word[31:28] != 4'd0) |=> status_word[5]);

    // R7: ready follows the unread count
    a_r7_rx_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[4] == (status_word[31:28] != 4'd0));

    // R9: empty implies the FIFO side is ready
    a_r9_empty_needs_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[1] |-> status_word[0]);

    // R10: reserved positions stay zero
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & 32'h00FC_F0CC) == 32'd0);
endmodule

bind serport_status serport_status_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .tx_en       (tx_en),
    .tx_wr       (tx_wr),
    .tx_xfer     (tx_xfer),
    .rx_load     (rx_load),
    .rx_rd       (rx_rd),
    .rx_sync_evt (rx_sync_evt),
    .stat_rd     (stat_rd),
    .status_word (status_word)
);

// File: tb/tb_serport_status.sv
`timescale 1ns/1ps
module tb_serport_status;
    localparam int DEPTH = 8;
    localparam int WD_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 0, tx_en = 0, tx_wr = 0, tx_xfer = 0, tx_shift_idle = 0;
    logic rx_load = 0, rx_rd = 0, rx_sync_evt = 0, tx_sync_evt = 0;
    logic cmp1_evt = 0, cmp0_evt = 0, stat_rd = 0;
    logic [31:0] status_word;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    serport_status #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
        .tx_wr(tx_wr), .tx_xfer(tx_xfer), .tx_shift_idle(tx_shift_idle),
        .rx_load(rx_load), .rx_rd(rx_rd), .rx_sync_evt(rx_sync_evt),
        .tx_sync_evt(tx_sync_evt), .cmp1_evt(cmp1_evt), .cmp0_evt(cmp0_evt),
        .stat_rd(stat_rd), .status_word(status_word)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_strobes();
        tx_wr = 0; tx_xfer = 0; rx_load = 0; rx_rd = 0;
        rx_sync_evt = 0; tx_sync_evt = 0; cmp1_evt = 0; cmp0_evt = 0; stat_rd = 0;
    endtask

    task automatic do_read();
        stat_rd = 1; cyc(); clear_strobes();
    endtask

    task automatic test_reset();
        chk("R10 reset word", status_word, 32'd0);
        rst_n = 1; cyc(); cyc();
        chk("R10 word after reset release", status_word, 32'd0);
    endtask

    task automatic test_enables();
        tx_shift_idle = 1;
        rx_en = 1; tx_en = 1; cyc();
        chk("R3 rx enable bit17", 32'(status_word[17]), 32'd1);
        chk("R3 tx enable bit16", 32'(status_word[16]), 32'd1);
        chk("R2 free loaded with depth", 32'(status_word[27:24]), DEPTH);
        chk("R8 tx ready when empty", 32'(status_word[0]), 32'd1);
        chk("R9 tx empty with idle shifter", 32'(status_word[1]), 32'd1);
    endtask

    task automatic test_tx_count();
        for (int i = 0; i < 3; i++) begin tx_wr = 1; cyc(); clear_strobes(); end
        chk("R2 free after 3 writes", 32'(status_word[27:24]), 32'd5);
        chk("R8 tx ready low with queued data", 32'(status_word[0]), 32'd0);
        chk("R9 tx empty low with queued data", 32'(status_word[1]), 32'd0);
        tx_wr = 1; tx_xfer = 1; cyc(); clear_strobes();
        chk("R2 write and transfer together", 32'(status_word[27:24]), 32'd5);
        for (int i = 0; i < 4; i++) begin tx_xfer = 1; cyc(); clear_strobes(); end
        chk("R2 free saturates at depth", 32'(status_word[27:24]), DEPTH);
        chk("R8 tx ready after drain", 32'(status_word[0]), 32'd1);
        for (int i = 0; i < DEPTH + 1; i++) begin tx_wr = 1; cyc(); clear_strobes(); end
        chk("R2 free saturates at zero", 32'(status_word[27:24]), 32'd0);
        for (int i = 0; i < DEPTH; i++) begin tx_xfer = 1; cyc(); clear_strobes(); end
        tx_shift_idle = 0; cyc();
        chk("R9 tx empty waits for shifter", 32'(status_word[1]), 32'd0);
        chk("R8 tx ready ignores shifter", 32'(status_word[0]), 32'd1);
        tx_shift_idle = 1; cyc();
        chk("R9 tx empty after shifter idle", 32'(status_word[1]), 32'd1);
        tx_en = 0; cyc();
        chk("R2 free zero when disabled", 32'(status_word[27:24]), 32'd0);
        chk("R3 tx enable bit16 low", 32'(status_word[16]), 32'd0);
        tx_en = 1; cyc();
        chk("R2 free reloaded on enable", 32'(status_word[27:24]), DEPTH);
    endtask

    task automatic test_rx_count();
        rx_rd = 1; cyc(); clear_strobes();
        chk("R1 read at zero stays zero", 32'(status_word[31:28]), 32'd0);
        chk("R7 rx ready low when empty", 32'(status_word[4]), 32'd0);
        for (int i = 0; i < 3; i++) begin rx_load = 1; cyc(); clear_strobes(); end
        chk("R1 count after 3 loads", 32'(status_word[31:28]), 32'd3);
        chk("R7 rx ready high with data", 32'(status_word[4]), 32'd1);
        rx_load = 1; rx_rd = 1; cyc(); clear_strobes();
        chk("R1 load and read together", 32'(status_word[31:28]), 32'd3);
        for (int i = 0; i < 3; i++) begin rx_rd = 1; cyc(); clear_strobes(); end
        chk("R1 drained to zero", 32'(status_word[31:28]), 32'd0);
        chk("R7 rx ready low after drain", 32'(status_word[4]), 32'd0);
        for (int i = 0; i < DEPTH + 2; i++) begin rx_load = 1; cyc(); clear_strobes(); end
        chk("R1 count saturates at depth", 32'(status_word[31:28]), DEPTH);
        for (int i = 0; i < DEPTH; i++) begin rx_rd = 1; cyc(); clear_strobes(); end
        do_read();
    endtask

    task automatic test_overrun();
        chk("R6 overrun clear after read", 32'(status_word[5]), 32'd0);
        rx_load = 1; cyc(); clear_strobes();
        chk("R6 first load no overrun", 32'(status_word[5]), 32'd0);
        rx_load = 1; rx_rd = 1; cyc(); clear_strobes();
        chk("R6 load while last word read no overrun", 32'(status_word[5]), 32'd0);
        rx_load = 1; cyc(); clear_strobes();
        chk("R6 load on unread word sets overrun", 32'(status_word[5]), 32'd1);
        cyc();
        chk("R6 overrun stays set", 32'(status_word[5]), 32'd1);
        do_read();
        chk("R6 overrun cleared by status read", 32'(status_word[5]), 32'd0);
        rx_load = 1; stat_rd = 1; cyc(); clear_strobes();
        chk("R5 overrun during read kept", 32'(status_word[5]), 32'd1);
        for (int i = 0; i < 3; i++) begin rx_rd = 1; cyc(); clear_strobes(); end
        do_read();
    endtask

    task automatic test_sticky();
        for (int b = 0; b < 4; b++) begin
            rx_sync_evt = (b == 0); tx_sync_evt = (b == 1);
            cmp1_evt = (b == 2); cmp0_evt = (b == 3);
            cyc(); clear_strobes();
            chk("R4 event sets its flag", 32'(status_word[11:8]), 32'(4'b1000 >> b));
            cyc(); cyc();
            chk("R4 flag holds while idle", 32'(status_word[11:8]), 32'(4'b1000 >> b));
            do_read();
            chk("R4 flag cleared by read", 32'(status_word[11:8]), 32'd0);
        end
        rx_sync_evt = 1; cmp0_evt = 1; cyc(); clear_strobes();
        tx_sync_evt = 1; stat_rd = 1; cyc(); clear_strobes();
        chk("R5 event during read kept, others cleared", 32'(status_word[11:8]), 32'b0100);
        chk("R10 reserved bits zero while active", status_word & 32'h00FC_F0CC, 32'd0);
        do_read();
        chk("R4 all flags clear", 32'(status_word[11:8]), 32'd0);
    endtask

    initial begin
        cyc(); cyc();
        test_reset();
        test_enables();
        test_tx_count();
        test_rx_count();
        test_overrun();
        test_sticky();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(WD_CYCLES * 4);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule